// File: doc/BRIEF.md
# Address Line Mirror Tester

This engine looks for broken RAM address lines. A broken line makes two addresses that differ in a single bit land on the same storage word. The engine is given a region as a byte base and a byte size, and it holds one test address fixed. It flips one address bit at a time to form a target address. For every target inside the region it reads the target, writes the complement of that value to the test address, and reads the target again. If the second read returns the value just written, the two addresses alias and a fault is reported.

A run has two passes. The first uses the lowest word of the region as the test address, so a single one bit walks through zeros. The second uses the highest word, so single zero bits walk through ones. The engine drives an ordinary single-port synchronous RAM port with one cycle of read latency. It keeps the addresses and the bit mask of the first fault it finds. A verification input can force a fault at one chosen mask position.

Top module: `addr_mirror_tester`

## Requirements
- R1: The XOR mask of a pass starts at the word size in bytes (DW/8) and doubles after each position. The pass ends when the mask shifts out of the AW-bit address and becomes zero.
- R2: The target is the test address XOR the mask. It is accessed only when base <= target < base + size (size is AW+1 bits wide, so the region may reach the top of the address space). Targets outside the region cause no memory access.
- R3: Each accessed target takes exactly one write to memory: first a read of the target, then a write of its bitwise complement to the test address, then a second read of the target.
- R4: A fault is detected when the second read of a target equals the complement written to the test address. It is recorded with the test address, the target address and the mask.
- R5: The first pass uses the test address base. The second pass uses the test address base + size - DW/8, taken modulo 2^AW.
- R6: After a fault both passes still run to the end. Only the first fault's test address, target and mask are kept, and fail stays high until the next run starts.
- R7: busy rises in the cycle after start is accepted while idle, and done clears at the same time. When the run ends, busy falls and done rises. A start pulse seen while busy is ignored. The base, size and inject values are sampled when start is accepted.
- R8: While inject is high during a run, the second read at mask 1<<INJ_BIT (0x8000 by default) is replaced by the written complement. This forces a fault there whenever that target lies inside the region.
- R9: After reset, busy, done, fail, mem_en and the three fault fields are all zero.
- R10: On a memory without aliasing and with inject low, a run ends with fail low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a run while idle |
| inject | input | 1 | Force a fault at mask 1<<INJ_BIT |
| base | input | AW | Region base byte address, word aligned |
| size | input | AW+1 | Region size in bytes, word aligned, at least two words |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM byte address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid one cycle after a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run has finished |
| fail | output | 1 | A fault was found in the last run |
| flt_test | output | AW | Test address of the first fault |
| flt_target | output | AW | Target address of the first fault |
| flt_mask | output | AW | XOR mask of the first fault |

## Verification
A mask sequence that is wrong at any step moves the first fault to another mask, or changes how many writes the run makes. This shows up at the ports as soon as done rises. A faulty range decision changes the write count, which is the number of in-range targets across both passes, or adds a fault outside the region. Address aliasing in the bench memory is swept over every bit position, stuck both high and low, and over regions placed at the bottom, the middle and the top of the address space. A latch that overwrites the first fault shows a later mask in the reported fields.

// File: rtl/amt_pkg.sv
package amt_pkg;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_EVAL,
    WK_RDA,
    WK_CAP,
    WK_WR,
    WK_RDB,
    WK_CMP
  } walk_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LO,
    SQ_HI
  } seq_state_e;

endpackage

// File: rtl/amt_range_chk.sv
module amt_range_chk #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   size,
  output logic          in_rng
);
  logic [AW:0] lim;
  logic [AW:0] a_ext;
  logic [AW:0] b_ext;

  always_comb begin
    a_ext  = {1'b0, addr};
    b_ext  = {1'b0, base};
    lim    = b_ext + size;
    in_rng = (a_ext >= b_ext) && (a_ext < lim);
  end
endmodule

// File: rtl/amt_walker.sv
module amt_walker
  import amt_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int INJ_BIT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] test_addr,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   size,
  input  logic          inject,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          hit,
  output logic [AW-1:0] hit_target,
  output logic [AW-1:0] hit_mask,
  output logic          pass_done
);
  localparam int            WB        = DW / 8;
  localparam logic [AW-1:0] MASK_INIT = AW'(WB);
  localparam logic [AW-1:0] INJ_MASK  = AW'(1) << INJ_BIT;

  walk_state_e   st;
  logic [AW-1:0] mask;
  logic [AW-1:0] tgt_q;
  logic [DW-1:0] comp_q;
  logic [AW-1:0] target;
  logic          in_rng;
  logic [DW-1:0] readback;

  assign target = test_addr ^ mask;

  amt_range_chk #(.AW(AW)) u_rng (
    .addr   (target),
    .base   (base),
    .size   (size),
    .in_rng (in_rng)
  );

  always_comb begin
    readback = mem_rdata;
    if (inject && (mask == INJ_MASK))
      readback = comp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= WK_IDLE;
      mask       <= '0;
      tgt_q      <= '0;
      comp_q     <= '0;
      mem_en     <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      hit        <= 1'b0;
      hit_target <= '0;
      hit_mask   <= '0;
      pass_done  <= 1'b0;
    end else begin
      hit       <= 1'b0;
      pass_done <= 1'b0;
      case (st)
        WK_IDLE: begin
          mem_en <= 1'b0;
          mem_we <= 1'b0;
          if (go) begin
            mask <= MASK_INIT;
            st   <= WK_EVAL;
          end
        end
        WK_EVAL: begin
          if (mask == '0) begin
            pass_done <= 1'b1;
            st        <= WK_IDLE;
          end else if (in_rng) begin
            tgt_q    <= target;
            mem_en   <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= target;
            st       <= WK_RDA;
          end else begin
            mask <= mask << 1;
          end
        end
        WK_RDA: begin
          mem_en <= 1'b0;
          st     <= WK_CAP;
        end
        WK_CAP: begin
          comp_q    <= ~mem_rdata;
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= test_addr;
          mem_wdata <= ~mem_rdata;
          st        <= WK_WR;
        end
        WK_WR: begin
          mem_we   <= 1'b0;
          mem_addr <= tgt_q;
          st       <= WK_RDB;
        end
        WK_RDB: begin
          mem_en <= 1'b0;
          st     <= WK_CMP;
        end
        WK_CMP: begin
          if (readback == comp_q) begin
            hit        <= 1'b1;
            hit_target <= tgt_q;
            hit_mask   <= mask;
          end
          mask <= mask << 1;
          st   <= WK_EVAL;
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask)); // R1

  AST_MASK_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == WK_CMP) |=> (mask == ($past(mask) << 1))); // R1

  AST_READ_IN_REGION: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |->
      (({1'b0, mem_addr} >= {1'b0, base}) &&
       ({1'b0, mem_addr} < ({1'b0, base} + size)))); // R2

  AST_WRITE_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_addr == test_addr) && (mem_wdata == ~$past(mem_rdata)))); // R3

  AST_HIT_GEOMETRY: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($onehot(hit_mask) && (hit_target == (test_addr ^ hit_mask)))); // R4
endmodule

// File: rtl/amt_fault_latch.sv
module amt_fault_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hit,
  input  logic [AW-1:0] hit_test,
  input  logic [AW-1:0] hit_target,
  input  logic [AW-1:0] hit_mask,
  output logic          fail,
  output logic [AW-1:0] flt_test,
  output logic [AW-1:0] flt_target,
  output logic [AW-1:0] flt_mask
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fail       <= 1'b0;
      flt_test   <= '0;
      flt_target <= '0;
      flt_mask   <= '0;
    end else if (hit && !fail) begin
      fail       <= 1'b1;
      flt_test   <= hit_test;
      flt_target <= hit_target;
      flt_mask   <= hit_mask;
    end
  end

  AST_FIRST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (fail && $past(fail)) |->
      ($stable(flt_mask) && $stable(flt_target) && $stable(flt_test))); // R6
endmodule

// File: rtl/addr_mirror_tester.sv
module addr_mirror_tester
  import amt_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int INJ_BIT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          inject,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   size,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] flt_test,
  output logic [AW-1:0] flt_target,
  output logic [AW-1:0] flt_mask
);
  localparam int WB = DW / 8;

  seq_state_e    seq;
  logic [AW-1:0] base_q;
  logic [AW:0]   size_q;
  logic [AW-1:0] cur_test;
  logic          inj_q;
  logic          go;
  logic          clr;
  logic          hit;
  logic [AW-1:0] hit_target;
  logic [AW-1:0] hit_mask;
  logic          pass_done;

  assign clr = (seq == SQ_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq      <= SQ_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      base_q   <= '0;
      size_q   <= '0;
      cur_test <= '0;
      inj_q    <= 1'b0;
      go       <= 1'b0;
    end else begin
      go <= 1'b0;
      case (seq)
        SQ_IDLE: begin
          if (start) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            base_q   <= base;
            size_q   <= size;
            inj_q    <= inject;
            cur_test <= base;
            go       <= 1'b1;
            seq      <= SQ_LO;
          end
        end
        SQ_LO: begin
          if (pass_done) begin
            cur_test <= base_q + size_q[AW-1:0] - AW'(WB);
            go       <= 1'b1;
            seq      <= SQ_HI;
          end
        end
        SQ_HI: begin
          if (pass_done) begin
            busy <= 1'b0;
            done <= 1'b1;
            seq  <= SQ_IDLE;
          end
        end
        default: seq <= SQ_IDLE;
      endcase
    end
  end

  amt_walker #(.AW(AW), .DW(DW), .INJ_BIT(INJ_BIT)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .test_addr  (cur_test),
    .base       (base_q),
    .size       (size_q),
    .inject     (inj_q),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .hit        (hit),
    .hit_target (hit_target),
    .hit_mask   (hit_mask),
    .pass_done  (pass_done)
  );

  amt_fault_latch #(.AW(AW)) u_flt (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .hit        (hit),
    .hit_test   (cur_test),
    .hit_target (hit_target),
    .hit_mask   (hit_mask),
    .fail       (fail),
    .flt_test   (flt_test),
    .flt_target (flt_target),
    .flt_mask   (flt_mask)
  );

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !mem_en); // R7

  AST_SECOND_PASS_ADDR: assert property (@(posedge clk) disable iff (rst)
    ((seq == SQ_HI) && $past(seq == SQ_LO)) |->
      (cur_test == AW'(base_q + size_q - WB))); // R5
endmodule

// File: tb/sim_addr_mirror_tester.sv
`timescale 1ns/1ps
module sim_addr_mirror_tester;
  localparam int AW  = 10;
  localparam int DW  = 32;
  localparam int INJ = 8;
  localparam int WB  = DW / 8;
  localparam int NW  = (1 << AW) / WB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          inject = 1'b0;
  logic [AW-1:0] base = '0;
  logic [AW:0]   size = '0;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] rd_q = '0;
  logic          busy, done, fail;
  logic [AW-1:0] flt_test, flt_target, flt_mask;

  logic [DW-1:0] ram [NW];
  int ftype = 0;
  int fbit  = 2;
  int wr_cnt = 0;
  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  addr_mirror_tester #(.AW(AW), .DW(DW), .INJ_BIT(INJ)) u0 (
    .clk(clk), .rst(rst), .start(start), .inject(inject),
    .base(base), .size(size),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(rd_q),
    .busy(busy), .done(done), .fail(fail),
    .flt_test(flt_test), .flt_target(flt_target), .flt_mask(flt_mask)
  );

  function automatic int phys(input logic [AW-1:0] a);
    logic [AW-1:0] p;
    p = a;
    if (ftype == 1) p = a & ~(AW'(1) << fbit);
    if (ftype == 2) p = a | (AW'(1) << fbit);
    return int'(p) / WB;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        ram[phys(mem_addr)] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_q <= ram[phys(mem_addr)];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int b, input int s, input int inj, input bit poke);
    int e_wr, e_t, e_g, e_m, t, g;
    bit e_f;
    e_wr = 0; e_f = 0; e_t = 0; e_g = 0; e_m = 0;
    for (int p = 0; p < 2; p++) begin
      t = (p == 0) ? b : ((b + s - WB) % (1 << AW));
      for (int m = WB; m < (1 << AW); m = m * 2) begin
        g = t ^ m;
        if (g >= b && g < b + s) begin
          e_wr++;
          if (!e_f && ((ftype != 0 && m == (1 << fbit)) || (inj != 0 && m == (1 << INJ)))) begin
            e_f = 1; e_t = t; e_g = g; e_m = m;
          end
        end
      end
    end
    @(negedge clk);
    base = AW'(b); size = (AW+1)'(s); inject = inj[0]; start = 1'b1;
    wr_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    base = '0; size = '0; inject = 1'b0;
    chk("R7 busy after start", {31'd0, busy}, 32'd1);
    chk("R7 done cleared", {31'd0, done}, 32'd0);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 4000 && !done; k++) @(negedge clk);
    chk("R7 done at end", {31'd0, done}, 32'd1);
    chk("R7 busy at end", {31'd0, busy}, 32'd0);
    chk("R2 R3 write count", wr_cnt, e_wr);
    chk(e_f ? "R4 fail flag" : "R10 fail flag", {31'd0, fail}, {31'd0, e_f});
    if (e_f) begin
      chk("R5 R6 fault test address", flt_test, e_t);
      chk("R2 R4 fault target", flt_target, e_g);
      chk((inj != 0 && e_m == (1 << INJ)) ? "R8 fault mask" : "R1 R6 fault mask", flt_mask, e_m);
    end
    repeat (3) @(negedge clk);
    chk("R6 result held", {31'd0, fail}, {31'd0, e_f});
  endtask

  initial begin
    int rb [4];
    int rs [4];
    rb = '{0, 'h100, 'h40, 'h3E0};
    rs = '{1024, 'h100, 'h2C0, 'h20};
    for (int i = 0; i < NW; i++) ram[i] = 32'h9E3779B9 * (i + 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 busy", {31'd0, busy}, 32'd0);
    chk("R9 done", {31'd0, done}, 32'd0);
    chk("R9 fail", {31'd0, fail}, 32'd0);
    chk("R9 mem_en", {31'd0, mem_en}, 32'd0);
    chk("R9 fault fields", {2'b0, flt_test, flt_target, flt_mask}, 32'd0);
    for (int r = 0; r < 4; r++) begin
      for (int inj = 0; inj < 2; inj++) begin
        ftype = 0;
        run(rb[r], rs[r], inj, inj == 0);
        for (int ty = 1; ty < 3; ty++) begin
          for (int bt = 2; bt < AW; bt++) begin
            ftype = ty; fbit = bt;
            run(rb[r], rs[r], inj, 1'b0);
          end
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule